// File: doc/BRIEF.md
# Sequenced Selective State Capture

This block records the states of a system under test into a capture memory. It does not sample on its own clock. A state exists only when the system's clock line, sampled by the block, shows the selected edge, either rising or falling. At that edge the memory-request qualifier must also be low. The read and write strobes then sort each state into one of two phases. With both strobes high it is an address phase. With either strobe low it is a data phase on the same lines. Each stored word carries a tag bit that records the phase.

Software arms the block with a one-cycle pulse and picks one of two modes.

- **Trigger mode:** the first state that matches a masked start pattern begins storage, and storing continues until the memory is full.
- **Sequence mode:** an address-phase state matching the start pattern opens a window. Every state after it is stored until an address-phase state matches the end pattern. That state is stored, and storage stops. A full memory also ends the window.

Top module: `seq_state_capture`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `stage` is 0 (IDLE) and `cap_we` is low. Stage codes are 0 IDLE, 1 ARMED, 2 STORING and 3 DONE.
- R2: A state is taken only on the selected edge of `sut_clk`: rising when `edge_sel` is 0, falling when it is 1. Bus changes while `sut_clk` holds its level produce no write. A write appears two `clk` cycles after the first cycle in which the new `sut_clk` level is present at the input.
- R3: An edge with `mreq_n` high is not a state and is never stored or matched.
- R4: `cap_wdata[BUS_W]` is 0 for an address phase (`rd_n` and `wr_n` both high) and 1 for a data phase (either strobe low). `cap_wdata[BUS_W-1:0]` is the bus value at the edge.
- R5: A bit set in `start_mask` or `end_mask` makes that bus bit a don't-care in the matching comparison. A cleared bit must equal the pattern bit.
- R6: With `mode_seq` 0 at arm time, the first state of either phase that matches the start pattern is written at address 0. Every later state is written at consecutive addresses until address 2^MEM_AW-1 has been written, and then `stage` becomes 3.
- R7: With `mode_seq` 1 at arm time, only an address-phase state can match the start pattern. All states from the start onward are stored. An address-phase state that matches the end pattern is stored, and then `stage` becomes 3.
- R8: In sequence mode, filling the last address also moves `stage` to 3, even when no end pattern has been seen.
- R9: An `arm` pulse in any stage moves `stage` to 1 and restarts addressing at 0. No write happens in IDLE or DONE.
- R10: The mode is latched when `arm` is pulsed. Changing `mode_seq` afterwards has no effect until the next arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than `sut_clk` |
| rst_n | input | 1 | Synchronous reset, active low |
| arm | input | 1 | One-cycle pulse that starts a new capture |
| mode_seq | input | 1 | 0 trigger mode, 1 sequence mode (latched on arm) |
| edge_sel | input | 1 | 0 rising, 1 falling edge of `sut_clk` marks a state |
| sut_clk | input | 1 | Clock line of the system under test |
| mreq_n | input | 1 | Memory-request qualifier, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| bus | input | BUS_W | Multiplexed address/data lines |
| start_pat | input | BUS_W | Start pattern |
| start_mask | input | BUS_W | Start don't-care mask |
| end_pat | input | BUS_W | End pattern |
| end_mask | input | BUS_W | End don't-care mask |
| cap_we | output | 1 | Capture memory write enable |
| cap_addr | output | MEM_AW | Capture memory write address |
| cap_wdata | output | BUS_W+1 | Phase tag above the bus word |
| stage | output | 2 | Sequencer stage code |

## Verification
The stimulus mixes address and data phases that carry the same bus value. This separates sequence mode, which opens only on an address phase, from trigger mode, which opens on either phase. Cycles with `mreq_n` high, and bus wiggles made while `sut_clk` holds its level, show that only qualified edges count. A run on falling edges shows that the edge select is honoured. Long runs without an end match show that a full memory stops storage. A re-arm in the middle of storing, and a mode change after arming, show the restart and the latching of the mode.

// File: rtl/seq_state_capture.sv
module seq_state_capture #(
  parameter int BUS_W  = 16,
  parameter int MEM_AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              mode_seq,
  input  logic              edge_sel,
  input  logic              sut_clk,
  input  logic              mreq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [BUS_W-1:0]  bus,
  input  logic [BUS_W-1:0]  start_pat,
  input  logic [BUS_W-1:0]  start_mask,
  input  logic [BUS_W-1:0]  end_pat,
  input  logic [BUS_W-1:0]  end_mask,
  output logic              cap_we,
  output logic [MEM_AW-1:0] cap_addr,
  output logic [BUS_W:0]    cap_wdata,
  output logic [1:0]        stage
);

  localparam logic [1:0] ST_IDLE  = 2'd0;
  localparam logic [1:0] ST_ARMED = 2'd1;
  localparam logic [1:0] ST_STORE = 2'd2;
  localparam logic [1:0] ST_DONE  = 2'd3;

  logic             smp_clk, smp_prev, smp_mreq_n, smp_rd_n, smp_wr_n;
  logic [BUS_W-1:0] smp_bus;
  logic [MEM_AW-1:0] cnt;
  logic             seq_r;

  logic edge_seen, qual, is_data, start_hit, end_hit, store, finish;

  assign edge_seen = edge_sel ? (smp_prev & ~smp_clk) : (~smp_prev & smp_clk);
  assign qual      = edge_seen & ~smp_mreq_n;
  assign is_data   = ~smp_rd_n | ~smp_wr_n;
  assign start_hit = qual & (((smp_bus ^ start_pat) & ~start_mask) == '0) & (~seq_r | ~is_data);
  assign end_hit   = qual & ~is_data & (((smp_bus ^ end_pat) & ~end_mask) == '0);
  assign store     = ((stage == ST_ARMED) & start_hit) | ((stage == ST_STORE) & qual);
  assign finish    = (&cnt) | ((stage == ST_STORE) & seq_r & end_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_clk    <= 1'b0;
      smp_prev   <= 1'b0;
      smp_mreq_n <= 1'b1;
      smp_rd_n   <= 1'b1;
      smp_wr_n   <= 1'b1;
      smp_bus    <= '0;
      cnt        <= '0;
      seq_r      <= 1'b0;
      stage      <= ST_IDLE;
      cap_we     <= 1'b0;
      cap_addr   <= '0;
      cap_wdata  <= '0;
    end else begin
      smp_clk    <= sut_clk;
      smp_prev   <= smp_clk;
      smp_mreq_n <= mreq_n;
      smp_rd_n   <= rd_n;
      smp_wr_n   <= wr_n;
      smp_bus    <= bus;
      cap_we     <= 1'b0;
      if (arm) begin
        stage <= ST_ARMED;
        cnt   <= '0;
        seq_r <= mode_seq;
      end else if (store) begin
        cap_we    <= 1'b1;
        cap_addr  <= cnt;
        cap_wdata <= {is_data, smp_bus};
        cnt       <= cnt + 1'b1;
        stage     <= finish ? ST_DONE : ST_STORE;
      end
    end
  end

endmodule

// File: rtl/seq_state_capture_chk.sv
module seq_state_capture_chk #(
  parameter int BUS_W  = 16,
  parameter int MEM_AW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arm,
  input logic              sut_clk,
  input logic              mreq_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic              cap_we,
  input logic [MEM_AW-1:0] cap_addr,
  input logic [BUS_W:0]    cap_wdata,
  input logic [1:0]        stage
);

  a_r1_reset_idle: assert property (@(posedge clk) $rose(rst_n) |-> (stage == 2'd0 && !cap_we));

  a_r2_edge_before_write: assert property (@(posedge clk) disable iff (!rst_n)
    cap_we |-> ($past(sut_clk, 2) != $past(sut_clk, 3)));

  a_r3_qualified_write: assert property (@(posedge clk) disable iff (!rst_n)
    cap_we |-> !$past(mreq_n, 2));

  a_r4_phase_tag: assert property (@(posedge clk) disable iff (!rst_n)
    cap_we |-> (cap_wdata[BUS_W] == (!$past(rd_n, 2) || !$past(wr_n, 2))));

  a_r8_last_entry_done: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_we && (&cap_addr)) |-> (stage == 2'd3));

  a_r9_write_only_active: assert property (@(posedge clk) disable iff (!rst_n)
    cap_we |-> ($past(stage) == 2'd1 || $past(stage) == 2'd2));

  a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 2'd3 && !arm) |=> (stage == 2'd3));

  a_r9_arm_enters_armed: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (stage == 2'd1 && !cap_we));

endmodule

bind seq_state_capture seq_state_capture_chk #(.BUS_W(BUS_W), .MEM_AW(MEM_AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .arm(arm), .sut_clk(sut_clk), .mreq_n(mreq_n),
  .rd_n(rd_n), .wr_n(wr_n), .cap_we(cap_we), .cap_addr(cap_addr),
  .cap_wdata(cap_wdata), .stage(stage)
);

// File: tb/seq_state_capture_tb.sv
module seq_state_capture_tb_top;
  localparam int BUS_W  = 16;
  localparam int MEM_AW = 3;
  localparam int DEPTH  = 1 << MEM_AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0, mode_seq = 1'b0, edge_sel = 1'b0, sut_clk = 1'b0;
  logic mreq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [BUS_W-1:0] bus = '0, start_pat = '0, start_mask = '0, end_pat = '0, end_mask = '0;
  logic cap_we;
  logic [MEM_AW-1:0] cap_addr;
  logic [BUS_W:0] cap_wdata;
  logic [1:0] stage;

  int errors = 0, checks = 0, n_writes = 0, cycles = 0;
  string cur_req = "R1";
  bit done_flag = 0;

  seq_state_capture #(.BUS_W(BUS_W), .MEM_AW(MEM_AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .arm(arm), .mode_seq(mode_seq), .edge_sel(edge_sel),
    .sut_clk(sut_clk), .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n), .bus(bus),
    .start_pat(start_pat), .start_mask(start_mask), .end_pat(end_pat), .end_mask(end_mask),
    .cap_we(cap_we), .cap_addr(cap_addr), .cap_wdata(cap_wdata), .stage(stage)
  );

  always #2 clk = ~clk;

  // behavioural reference: a history of sampled inputs and a stage number
  int m_stage = 0, m_cnt = 0, m_we = 0, m_addr = 0, m_data = 0;
  bit m_seq = 0;
  int hist_clk[$], hist_mreq[$], hist_rd[$], hist_wr[$], hist_bus[$];

  function automatic bit fits(int v, int pat, int mask);
    return ((v ^ pat) & ~mask & 32'hFFFF) == 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stage = 0; m_cnt = 0; m_we = 0; m_seq = 0;
      hist_clk = {0, 0}; hist_mreq = {1}; hist_rd = {1}; hist_wr = {1}; hist_bus = {0};
    end else begin
      bit edge_now, q, dphase, hit_s, hit_e;
      edge_now = edge_sel ? (hist_clk[0] == 1 && hist_clk[1] == 0)
                          : (hist_clk[0] == 0 && hist_clk[1] == 1);
      q = edge_now && hist_mreq[0] == 0;
      dphase = (hist_rd[0] == 0) || (hist_wr[0] == 0);
      hit_s = q && fits(hist_bus[0], start_pat, start_mask) && (!m_seq || !dphase);
      hit_e = q && !dphase && fits(hist_bus[0], end_pat, end_mask);
      m_we = 0;
      if (arm) begin
        m_stage = 1; m_cnt = 0; m_seq = mode_seq;
      end else if ((m_stage == 1 && hit_s) || (m_stage == 2 && q)) begin
        m_we = 1; m_addr = m_cnt; m_data = {15'd0, dphase, hist_bus[0][15:0]};
        if (m_cnt == DEPTH - 1 || (m_stage == 2 && m_seq && hit_e)) m_stage = 3;
        else m_stage = 2;
        m_cnt = (m_cnt + 1) % DEPTH;
      end
      void'(hist_clk.pop_front());
      hist_clk.push_back(int'(sut_clk));
      hist_mreq[0] = int'(mreq_n); hist_rd[0] = int'(rd_n);
      hist_wr[0] = int'(wr_n); hist_bus[0] = int'(bus);
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done_flag) begin
      check(cur_req, "stage", int'(stage), m_stage);
      check(cur_req, "cap_we", int'(cap_we), m_we);
      if (m_we == 1 && cap_we) begin
        check(cur_req, "cap_addr", int'(cap_addr), m_addr);
        check(cur_req, "cap_wdata", int'(cap_wdata), m_data);
      end
      if (cap_we) n_writes++;
    end
  end

  task automatic state(input logic [15:0] v, input logic mq, input logic rd, input logic wr);
    @(negedge clk);
    bus = v; mreq_n = mq; rd_n = rd; wr_n = wr;
    sut_clk = edge_sel;
    repeat (2) @(negedge clk);
    sut_clk = ~edge_sel;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_arm(input logic m);
    @(negedge clk);
    mode_seq = m; arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    n_writes = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1", "stage in reset", int'(stage), 0);
    check("R1", "cap_we in reset", int'(cap_we), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "stage after reset", int'(stage), 0);

    cur_req = "R6";
    start_pat = 16'h1234; start_mask = 16'h0000;
    do_arm(1'b0);
    state(16'h1111, 0, 1, 1);
    state(16'h1234, 0, 0, 1);
    for (int i = 0; i < 9; i++) state(16'hA000 + 16'(i), 0, (i % 2 == 0), 1);
    repeat (3) @(negedge clk);
    check("R6", "writes until full", n_writes, DEPTH);
    check("R6", "stage done", int'(stage), 3);

    cur_req = "R7";
    start_pat = 16'h0100; start_mask = 16'h00FF; end_pat = 16'h0200; end_mask = 16'h0000;
    do_arm(1'b1);
    state(16'h0100, 0, 0, 1);
    state(16'h0300, 0, 1, 1);
    state(16'h0155, 0, 1, 1);
    state(16'h00AA, 0, 1, 0);
    state(16'h0200, 0, 1, 1);
    state(16'h0155, 0, 1, 1);
    repeat (3) @(negedge clk);
    check("R7", "window writes", n_writes, 3);
    check("R5", "masked start then end", int'(stage), 3);

    cur_req = "R8";
    do_arm(1'b1);
    state(16'h01F0, 0, 1, 1);
    for (int i = 0; i < 10; i++) state(16'h0500 + 16'(i), 0, 1, (i % 3 != 0));
    repeat (3) @(negedge clk);
    check("R8", "full ends sequence", n_writes, DEPTH);
    check("R8", "stage done", int'(stage), 3);

    cur_req = "R3";
    edge_sel = 1'b1; sut_clk = 1'b1;
    repeat (3) @(negedge clk);
    start_mask = 16'hFFFF;
    do_arm(1'b0);
    state(16'h7777, 1, 1, 1);
    check("R3", "unqualified edge", n_writes, 0);
    cur_req = "R2";
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      bus = 16'h3000 + 16'(i); mreq_n = 1'b0;
    end
    repeat (3) @(negedge clk);
    check("R2", "bus wiggle without edge", n_writes, 0);
    state(16'h4001, 0, 1, 1);
    state(16'h4002, 0, 0, 1);
    state(16'h4003, 0, 1, 0);
    cur_req = "R3";
    state(16'h4004, 1, 0, 1);
    repeat (3) @(negedge clk);
    check("R2", "falling edge states", n_writes, 3);
    check("R3", "storing ignores mreq high", int'(stage), 2);

    cur_req = "R10";
    edge_sel = 1'b0; sut_clk = 1'b0;
    start_pat = 16'h0100; start_mask = 16'h00FF;
    do_arm(1'b1);
    mode_seq = 1'b0;
    state(16'h0100, 0, 0, 1);
    repeat (3) @(negedge clk);
    check("R10", "latched seq mode", n_writes, 0);
    check("R10", "still armed", int'(stage), 1);

    cur_req = "R9";
    state(16'h0101, 0, 1, 1);
    state(16'h0011, 0, 0, 1);
    check("R9", "two stored", n_writes, 2);
    do_arm(1'b1);
    check("R9", "rearm stage", int'(stage), 1);
    state(16'h0102, 0, 1, 1);
    repeat (3) @(negedge clk);
    check("R9", "restart writes", n_writes, 1);
    check("R4", "address tag", int'(cap_wdata[BUS_W]), 0);
    check("R9", "restart address", int'(cap_addr), 0);

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected<20000 cycles", cycles);
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule